// File: doc/BRIEF.md
# PVT Code Capture and Drive-Segment Controller

This block turns a delay-line snapshot into a drive-strength setting for a segmented output driver. A launched high level runs down a delay chain. The tap outputs arrive here as a thermometer vector: fast silicon lets the level reach more taps, and slow silicon leaves most taps at zero. On every falling edge of the reference clock the block registers the taps. It locates the highest tap that reads 1 and expresses that position as a one-hot pre-control word. It then compresses the word to a binary code.

Each bit of the code switches on one binary-weighted extra driver segment. Bit 0 drives the smallest segment, and the most significant bit drives the largest. A base pull-up and pull-down pair is always available. The data bit selects the pull-up or pull-down side. When output enable is low, every enable is off, which tri-states the pad. Code 0 is the slowest setting and uses only the base pair. The code width is a parameter. The default is 3 bits with 8 taps, and a 4-bit build with 16 taps is supported.

Top module: `pvt_drive_ctrl`

## Requirements
- R1: The tap vector is registered only on the falling edge of `ref_clk`. A change on `taps` while the clock is high leaves `code` unchanged until the next falling edge.
- R2: `code` equals the bit index of the highest registered tap that reads 1. A registered tap vector of all zeros gives code 0.
- R3: A registered tap vector of all ones gives the largest code, TAPS-1 (7 for the default build).
- R4: `pre_onehot` has exactly one bit set, at bit position `code`.
- R5: Zeros below the highest 1 in the tap vector (bubbles) do not change the code. Only the position of the highest 1 counts.
- R6: Pull-up segment i is enabled exactly when `oe`, `dout` and `code[i]` are all 1. Pull-down segment i is enabled exactly when `oe` is 1, `dout` is 0 and `code[i]` is 1.
- R7: The base pull-up enable equals `oe & dout`, and the base pull-down enable equals `oe & ~dout`, whatever the code.
- R8: While `oe` is 0, every pull-up and pull-down enable is 0, including the base pair.
- R9: An active-low `rst_n` clears the registered taps at once. The result is code 0 and `pre_onehot` equal to 1.
- R10: With CODE_W=4 the block takes 16 taps, produces a 16-bit one-hot word and a 4-bit code, and applies the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; taps are captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| taps | input | TAPS | Delay-chain tap vector (thermometer, bit 0 nearest the launch point) |
| dout | input | 1 | Output data bit |
| oe | input | 1 | Output enable; low tri-states the pad |
| code | output | CODE_W | Binary drive-strength code |
| pre_onehot | output | TAPS | One-hot pre-control word |
| pu_base_en | output | 1 | Base pull-up enable |
| pd_base_en | output | 1 | Base pull-down enable |
| pu_seg_en | output | CODE_W | Weighted pull-up segment enables |
| pd_seg_en | output | CODE_W | Weighted pull-down segment enables |

## Verification
On every cycle, the assertions check four things. The one-hot word has exactly one bit set, and that bit agrees with the encoded code. No registered tap above the code's position reads 1. The segment enables match the code and never turn on both sides together. A low output enable silences every driver. The bench's scenarios show what the assertions cannot. It sweeps every tap pattern of both the 3-bit and the 4-bit build, and compares each result with the expected value computed from the highest 1. It changes the taps while the clock is high to show that the code waits for the falling edge. It applies reset in the middle of a run to show that the code returns to its slowest value.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
  localparam int unsigned MAX_TAPS = 64;

  // Select mask for code bit b: every one-hot position whose index has bit b set.
  function automatic logic [MAX_TAPS-1:0] code_bit_mask(input int unsigned b,
                                                         input int unsigned n);
    logic [MAX_TAPS-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < n; i++) begin
      if (((i >> b) & 1) == 1) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pvt_tap_capture.sv
module pvt_tap_capture #(
  parameter int unsigned TAPS = 8
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] taps_in,
  output logic [TAPS-1:0] taps_q
);
  // Sample on the high-to-low transition; reset gives the slowest snapshot.
  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= taps_in;
  end
endmodule

// File: rtl/pvt_therm_onehot.sv
module pvt_therm_onehot #(
  parameter int unsigned TAPS = 8
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] therm,
  output logic [TAPS-1:0] onehot
);
  // A position is marked when its tap is 1 and no tap above it is 1.
  // Position 0 also takes the empty vector, so the word is never zero.
  genvar i;
  generate
    for (i = 0; i < TAPS; i++) begin : g_pos
      if (i == TAPS - 1) begin : g_top
        assign onehot[i] = therm[i];
      end else if (i == 0) begin : g_bot
        assign onehot[i] = ~|therm[TAPS-1:1];
      end else begin : g_mid
        assign onehot[i] = therm[i] & ~|therm[TAPS-1:i+1];
      end
    end
  endgenerate

  p_onehot_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $countones(onehot) == 1);
endmodule

// File: rtl/pvt_onehot_enc.sv
module pvt_onehot_enc #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned TAPS = 1 << CODE_W
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [TAPS-1:0]   onehot,
  output logic [CODE_W-1:0] code
);
  import pvt_pkg::*;

  genvar b;
  generate
    for (b = 0; b < CODE_W; b++) begin : g_bit
      localparam logic [MAX_TAPS-1:0] MASK = code_bit_mask(b, TAPS);
      assign code[b] = |(onehot & MASK[TAPS-1:0]);
    end
  endgenerate

  p_code_points_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    onehot[code] == 1'b1);
endmodule

// File: rtl/pvt_seg_gate.sv
module pvt_seg_gate #(
  parameter int unsigned CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  input  logic              dout,
  input  logic              oe,
  output logic              pu_base_en,
  output logic              pd_base_en,
  output logic [CODE_W-1:0] pu_seg_en,
  output logic [CODE_W-1:0] pd_seg_en
);
  logic drive_hi, drive_lo;
  assign drive_hi   = oe & dout;
  assign drive_lo   = oe & ~dout;
  assign pu_base_en = drive_hi;
  assign pd_base_en = drive_lo;

  genvar s;
  generate
    for (s = 0; s < CODE_W; s++) begin : g_seg
      assign pu_seg_en[s] = code[s] & drive_hi;
      assign pd_seg_en[s] = code[s] & drive_lo;
    end
  endgenerate
endmodule

// File: rtl/pvt_drive_ctrl.sv
module pvt_drive_ctrl #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned TAPS = 1 << CODE_W
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [TAPS-1:0]   taps,
  input  logic              dout,
  input  logic              oe,
  output logic [CODE_W-1:0] code,
  output logic [TAPS-1:0]   pre_onehot,
  output logic              pu_base_en,
  output logic              pd_base_en,
  output logic [CODE_W-1:0] pu_seg_en,
  output logic [CODE_W-1:0] pd_seg_en
);
  logic [TAPS-1:0] taps_q;

  pvt_tap_capture #(.TAPS(TAPS)) u_cap (
    .ref_clk(ref_clk), .rst_n(rst_n), .taps_in(taps), .taps_q(taps_q));

  pvt_therm_onehot #(.TAPS(TAPS)) u_oh (
    .ref_clk(ref_clk), .rst_n(rst_n), .therm(taps_q), .onehot(pre_onehot));

  pvt_onehot_enc #(.CODE_W(CODE_W)) u_enc (
    .ref_clk(ref_clk), .rst_n(rst_n), .onehot(pre_onehot), .code(code));

  pvt_seg_gate #(.CODE_W(CODE_W)) u_gate (
    .code(code), .dout(dout), .oe(oe),
    .pu_base_en(pu_base_en), .pd_base_en(pd_base_en),
    .pu_seg_en(pu_seg_en), .pd_seg_en(pd_seg_en));

  // Bubble tolerance: no registered tap above the code position is 1.
  p_no_tap_above_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((taps_q >> code) >> 1) == '0);

  p_seg_match_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    oe |-> ((pu_seg_en | pd_seg_en) == code));

  p_side_excl_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !((pu_base_en | (|pu_seg_en)) && (pd_base_en | (|pd_seg_en))));

  p_tristate_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !oe |-> (!pu_base_en && !pd_base_en && pu_seg_en == '0 && pd_seg_en == '0));
endmodule

// File: tb/sim_pvt_drive_ctrl.sv
module sim_pvt_drive_ctrl;
  logic clk = 1'b1;
  logic rst_n = 1'b0;
  logic [15:0] t16 = '0;
  logic dout = 1'b0, oe = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  logic [2:0] c0; logic [7:0] oh0; logic pub0, pdb0; logic [2:0] pus0, pds0;
  logic [3:0] c1; logic [15:0] oh1; logic pub1, pdb1; logic [3:0] pus1, pds1;

  pvt_drive_ctrl u0 (.ref_clk(clk), .rst_n(rst_n), .taps(t16[7:0]), .dout(dout), .oe(oe),
    .code(c0), .pre_onehot(oh0), .pu_base_en(pub0), .pd_base_en(pdb0),
    .pu_seg_en(pus0), .pd_seg_en(pds0));

  pvt_drive_ctrl #(.CODE_W(4)) u1 (.ref_clk(clk), .rst_n(rst_n), .taps(t16), .dout(dout),
    .oe(oe), .code(c1), .pre_onehot(oh1), .pu_base_en(pub1), .pd_base_en(pdb1),
    .pu_seg_en(pus1), .pd_seg_en(pds1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Highest set index, scanning upward and keeping the last hit.
  function automatic int top_idx(input logic [15:0] v, input int n);
    int r = 0;
    for (int k = 0; k < n; k++) if (v[k]) r = k;
    return r;
  endfunction

  function automatic int ones(input logic [15:0] v, input int n);
    int r = 0;
    for (int k = 0; k < n; k++) r += int'(v[k]);
    return r;
  endfunction

  task automatic check_outputs(input logic [15:0] v);
    int e0, e1, hi, lo;
    string tag;
    e0 = top_idx(v, 8);
    e1 = top_idx(v, 16);
    hi = int'(oe & dout);
    lo = int'(oe & ~dout);
    if (v[7:0] == 8'hFF) tag = "R3";
    else if (v[7:0] != 0 && ones(v, 8) != e0 + 1) tag = "R5";
    else tag = "R2";
    chk(tag, int'(c0), e0);
    chk("R4", int'(oh0), 1 << e0);
    chk("R6 pull-up", int'(pus0), hi != 0 ? e0 : 0);
    chk("R6 pull-down", int'(pds0), lo != 0 ? e0 : 0);
    chk("R7 base up", int'(pub0), hi);
    chk("R7 base down", int'(pdb0), lo);
    if (!oe) chk("R8", int'({pub0, pdb0, pus0, pds0, pub1, pdb1, pus1, pds1}), 0);
    chk("R10 code", int'(c1), e1);
    chk("R10 onehot", int'(oh1), 1 << e1);
    chk("R10 seg", int'(pus1 | pds1), oe ? e1 : 0);
  endtask

  initial begin
    #1;
    chk("R9 reset code", int'(c0), 0);
    chk("R9 reset onehot", int'(oh0), 1);
    chk("R8 reset oe low", int'({pub0, pdb0, pus0, pds0}), 0);
    #8 rst_n = 1'b1;
    @(posedge clk);
    for (int j = 0; j < 65536; j++) begin
      int prev0, prev1;
      prev0 = top_idx(t16, 8);
      prev1 = top_idx(t16, 16);
      #0.5;
      t16 = j[15:0];
      oe = (j % 5) != 0;
      dout = (j % 3) == 0;
      #0.5;
      chk("R1 hold", int'(c0), prev0);
      chk("R1 hold wide", int'(c1), prev1);
      @(negedge clk);
      #0.5;
      check_outputs(t16);
      @(posedge clk);
    end
    t16 = 16'hFFFF; oe = 1'b1; dout = 1'b1;
    @(negedge clk); #0.5;
    chk("R3 all ones", int'(c0), 7);
    rst_n = 1'b0;
    #0.5;
    chk("R9 mid-run code", int'(c0), 0);
    chk("R9 mid-run onehot", int'(oh0), 1);
    chk("R9 mid-run wide", int'(c1), 0);
    chk("R7 base under reset", int'(pub0), 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule